// File: doc/BRIEF.md
# Link Bandwidth Selector and M/N Ratio Calculator

This block runs once per video mode change. It takes the pixel clock of the mode (in kHz), the pixel depth used in panel mode, and the raw capability bytes the sink reported. It then picks the narrowest and slowest serial link configuration that can carry the stream. For that configuration it computes the two clock-recovery ratios the transmitter needs:

- a data ratio: stream bytes against link symbol capacity;
- a link ratio: pixel clock against link clock.

Each ratio is cut down to a fixed register width. The result also includes a packed data-M word that carries the transfer-unit size.

The work is sequential. A one-cycle `start` pulse while idle latches all inputs. `busy` stays high while the block computes. The two multiplications run as shift-add loops of eight steps each. The candidate search tests one lane/rate pair per cycle. The ratio reduction shifts one bit per cycle. `done` pulses for one cycle when the outputs take new values. `fail` rides on that pulse when the mode is rejected. The block has no streaming data path, so all pins are plain control and status pins. There is no back-pressure: results hold until the next completion and do not wait to be consumed.

Top module: `link_ratio_calc`

## Requirements
- R1: A request whose pixel clock is below MIN_PCLK_KHZ (10000) completes with `fail`=1 and `fail_slow`=1. A pixel clock of exactly 10000 is accepted.
- R2: Required bandwidth is pixel clock × 3 when `panel_mode`=0, and floor(pixel clock × `panel_bpp` / 8) when `panel_mode`=1.
- R3: Candidates are tried with lane counts 1, 2, 4 in that order, up to the maximum. Within each lane count the low rate (162000 kHz, code 0x06) is tried before the high rate (270000 kHz, code 0x0A). The first candidate with required ≤ link clock × lanes is chosen, so equality fits.
- R4: The maximum lane count is taken from `cap_lane_byte[4:0]` when `cap_rev` ≥ 0x11. A value other than 1, 2 or 4 counts as 4. With `cap_rev` < 0x11 the maximum is 4 and `cap_lane_byte` is ignored.
- R5: The high rate is allowed only when `cap_rate` = 0x0A. Any other code limits the search to the low rate. `rate_code` reports 0x06 or 0x0A.
- R6: When no candidate fits, the block completes with `fail`=1 and `fail_slow`=0. On any failure, `rate_code`, `lane_cnt`, all ratios and `data_m_word` are 0.
- R7: Data M = pixel clock × 3 and data N = link clock × lanes. Link M = pixel clock and link N = link clock. Each pair is shifted right together, one bit at a time, until both terms are ≤ 2^RATIO_W − 1.
- R8: `data_m_word` = {TU_SIZE − 1 in its upper 8 bits, data M in its lower RATIO_W bits}.
- R9: `start` is taken only while idle, and `start` while `busy` is ignored. `busy` is high from the cycle after an accepted start until completion. `done` is a one-cycle pulse, one per accepted request.
- R10: After reset all outputs are 0. Result outputs change only in the cycle `done` is high and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken while idle |
| pix_khz | input | PCLK_W | Pixel clock in kHz |
| panel_mode | input | 1 | 1: required bandwidth from `panel_bpp` |
| panel_bpp | input | 8 | Bits per pixel for panel mode |
| cap_rev | input | 8 | Sink capability revision |
| cap_lane_byte | input | 8 | Sink lane capability byte |
| cap_rate | input | 8 | Sink maximum rate code |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Mode rejected |
| fail_slow | output | 1 | Rejected because the pixel clock is too low |
| rate_code | output | 8 | Chosen rate code (0x06/0x0A, or 0) |
| lane_cnt | output | 3 | Chosen lane count (1/2/4, or 0) |
| data_m | output | RATIO_W | Reduced data M |
| data_n | output | RATIO_W | Reduced data N |
| link_m | output | RATIO_W | Reduced link M |
| link_n | output | RATIO_W | Reduced link N |
| data_m_word | output | RATIO_W+8 | Transfer-unit size minus one above data M |

## Verification
The bench builds the block with PCLK_W=20 and RATIO_W=16. The narrower ratio width makes every realistic mode overflow the ratio registers, so the joint-shift reduction runs for several steps on both pairs. At the default width of 24 it would never be reached. A pixel-clock width of 20 bits still covers the fail-fast case, where even four high-rate lanes fall short. It also covers exact-fit boundaries, panel-mode depths and the low-clock rejection limit.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam logic [7:0] RATE_LO_CODE = 8'h06;
  localparam logic [7:0] RATE_HI_CODE = 8'h0A;
  localparam int         LCLK_LO_KHZ  = 162000;
  localparam int         LCLK_HI_KHZ  = 270000;
  localparam logic [7:0] CAP_REV_LANES = 8'h11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_REQ,
    ST_SEARCH,
    ST_MUL_DM,
    ST_SHRINK
  } lrc_state_e;
endpackage

// File: rtl/lrc_cap_decode.sv
module lrc_cap_decode
  import lrc_pkg::*;
(
  input  logic [7:0] cap_rev,
  input  logic [7:0] cap_lane_byte,
  input  logic [7:0] cap_rate,
  output logic [1:0] max_lane_log,
  output logic       hi_rate_ok
);
  logic [4:0] lane_field;
  logic [2:0] unused_hi_bits;

  assign lane_field     = cap_lane_byte[4:0];
  assign unused_hi_bits = cap_lane_byte[7:5];

  always_comb begin
    max_lane_log = 2'd2;
    if (cap_rev >= CAP_REV_LANES) begin
      case (lane_field)
        5'd1:    max_lane_log = 2'd0;
        5'd2:    max_lane_log = 2'd1;
        default: max_lane_log = 2'd2;
      endcase
    end
  end

  assign hi_rate_ok = (cap_rate == RATE_HI_CODE);
endmodule

// File: rtl/lrc_shift_mul.sv
module lrc_shift_mul #(
  parameter int A_W = 20,
  parameter int B_W = 8,
  parameter int P_W = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           busy,
  output logic [P_W-1:0] prod
);
  localparam int CNT_W = $clog2(B_W + 1);

  logic [P_W-1:0]   acc_q, mcand_q;
  logic [B_W-1:0]   mplier_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
    end else if (go) begin
      acc_q    <= '0;
      mcand_q  <= P_W'(a);
      mplier_q <= b;
      cnt_q    <= CNT_W'(B_W);
      run_q    <= 1'b1;
    end else if (run_q) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= {mcand_q[P_W-2:0], 1'b0};
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign busy = run_q | go;
  assign prod = acc_q;
endmodule

// File: rtl/lrc_ratio_shrink.sv
module lrc_ratio_shrink #(
  parameter int IN_W  = 28,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [IN_W-1:0]  num_in,
  input  logic [IN_W-1:0]  den_in,
  output logic             busy,
  output logic [OUT_W-1:0] num_out,
  output logic [OUT_W-1:0] den_out
);
  logic [IN_W-1:0] num_q, den_q;
  logic            run_q;
  logic            too_big;

  assign too_big = (|num_q[IN_W-1:OUT_W]) | (|den_q[IN_W-1:OUT_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
      run_q <= 1'b0;
    end else if (go) begin
      num_q <= num_in;
      den_q <= den_in;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (too_big) begin
        num_q <= num_q >> 1;
        den_q <= den_q >> 1;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign busy    = run_q | go;
  assign num_out = num_q[OUT_W-1:0];
  assign den_out = den_q[OUT_W-1:0];
endmodule

// File: rtl/link_ratio_calc.sv
module link_ratio_calc
  import lrc_pkg::*;
#(
  parameter int PCLK_W       = 20,
  parameter int RATIO_W      = 24,
  parameter int TU_SIZE      = 64,
  parameter int TU_FIELD_W   = 8,
  parameter int MIN_PCLK_KHZ = 10000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [PCLK_W-1:0]             pix_khz,
  input  logic                          panel_mode,
  input  logic [7:0]                    panel_bpp,
  input  logic [7:0]                    cap_rev,
  input  logic [7:0]                    cap_lane_byte,
  input  logic [7:0]                    cap_rate,
  output logic                          busy,
  output logic                          done,
  output logic                          fail,
  output logic                          fail_slow,
  output logic [7:0]                    rate_code,
  output logic [2:0]                    lane_cnt,
  output logic [RATIO_W-1:0]            data_m,
  output logic [RATIO_W-1:0]            data_n,
  output logic [RATIO_W-1:0]            link_m,
  output logic [RATIO_W-1:0]            link_n,
  output logic [RATIO_W+TU_FIELD_W-1:0] data_m_word
);
  localparam int MUL_W  = PCLK_W + 8;
  localparam int WIDE_W = (MUL_W > RATIO_W) ? MUL_W : RATIO_W + 1;
  localparam logic [PCLK_W-1:0]     MIN_PCLK  = PCLK_W'(MIN_PCLK_KHZ);
  localparam logic [WIDE_W-1:0]     LCLK_LO_W = WIDE_W'(LCLK_LO_KHZ);
  localparam logic [WIDE_W-1:0]     LCLK_HI_W = WIDE_W'(LCLK_HI_KHZ);
  localparam logic [TU_FIELD_W-1:0] TU_M1     = TU_FIELD_W'(TU_SIZE - 1);

  lrc_state_e state_q;

  logic [PCLK_W-1:0] pclk_q;
  logic              panel_q;
  logic [1:0]        max_ll_q, dec_ll;
  logic              hi_ok_q, dec_hi;
  logic [WIDE_W-1:0] req_q;
  logic [1:0]        lane_log_q;
  logic              rate_hi_q;

  logic              mul_go, mul_busy;
  logic [7:0]        mul_b;
  logic [WIDE_W-1:0] mul_prod;

  logic              red_go, red_busy_d, red_busy_l;
  logic [WIDE_W-1:0] dm_in, dn_in, lm_in, ln_in;
  logic [RATIO_W-1:0] dm_out, dn_out, lm_out, ln_out;

  logic [WIDE_W-1:0] lclk_w, avail;
  logic              fits;

  // Capability decode of the live inputs; latched on start
  lrc_cap_decode u_cap (
    .cap_rev      (cap_rev),
    .cap_lane_byte(cap_lane_byte),
    .cap_rate     (cap_rate),
    .max_lane_log (dec_ll),
    .hi_rate_ok   (dec_hi)
  );

  // One shared multiplier for required bandwidth and data M
  lrc_shift_mul #(.A_W(PCLK_W), .B_W(8), .P_W(WIDE_W)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (mul_go),
    .a    (pclk_q),
    .b    (mul_b),
    .busy (mul_busy),
    .prod (mul_prod)
  );

  // Two reducers run in parallel: data pair and link pair
  lrc_ratio_shrink #(.IN_W(WIDE_W), .OUT_W(RATIO_W)) u_red_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (red_go),
    .num_in (dm_in),
    .den_in (dn_in),
    .busy   (red_busy_d),
    .num_out(dm_out),
    .den_out(dn_out)
  );

  lrc_ratio_shrink #(.IN_W(WIDE_W), .OUT_W(RATIO_W)) u_red_link (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (red_go),
    .num_in (lm_in),
    .den_in (ln_in),
    .busy   (red_busy_l),
    .num_out(lm_out),
    .den_out(ln_out)
  );

  assign lclk_w = rate_hi_q ? LCLK_HI_W : LCLK_LO_W;
  assign avail  = lclk_w << lane_log_q;
  assign fits   = (req_q <= avail);
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pclk_q      <= '0;
      panel_q     <= 1'b0;
      max_ll_q    <= '0;
      hi_ok_q     <= 1'b0;
      req_q       <= '0;
      lane_log_q  <= '0;
      rate_hi_q   <= 1'b0;
      mul_go      <= 1'b0;
      mul_b       <= '0;
      red_go      <= 1'b0;
      dm_in       <= '0;
      dn_in       <= '0;
      lm_in       <= '0;
      ln_in       <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
      fail_slow   <= 1'b0;
      rate_code   <= '0;
      lane_cnt    <= '0;
      data_m      <= '0;
      data_n      <= '0;
      link_m      <= '0;
      link_n      <= '0;
      data_m_word <= '0;
    end else begin
      done   <= 1'b0;
      mul_go <= 1'b0;
      red_go <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            pclk_q   <= pix_khz;
            panel_q  <= panel_mode;
            max_ll_q <= dec_ll;
            hi_ok_q  <= dec_hi;
            if (pix_khz < MIN_PCLK) begin
              done        <= 1'b1;
              fail        <= 1'b1;
              fail_slow   <= 1'b1;
              rate_code   <= '0;
              lane_cnt    <= '0;
              data_m      <= '0;
              data_n      <= '0;
              link_m      <= '0;
              link_n      <= '0;
              data_m_word <= '0;
            end else begin
              mul_go  <= 1'b1;
              mul_b   <= panel_mode ? panel_bpp : 8'd3;
              state_q <= ST_MUL_REQ;
            end
          end
        end
        ST_MUL_REQ: begin
          if (!mul_busy) begin
            req_q      <= panel_q ? (mul_prod >> 3) : mul_prod;
            lane_log_q <= 2'd0;
            rate_hi_q  <= 1'b0;
            state_q    <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (fits) begin
            mul_go  <= 1'b1;
            mul_b   <= 8'd3;
            state_q <= ST_MUL_DM;
          end else if (!rate_hi_q && hi_ok_q) begin
            rate_hi_q <= 1'b1;
          end else if (lane_log_q < max_ll_q) begin
            lane_log_q <= lane_log_q + 2'd1;
            rate_hi_q  <= 1'b0;
          end else begin
            done        <= 1'b1;
            fail        <= 1'b1;
            fail_slow   <= 1'b0;
            rate_code   <= '0;
            lane_cnt    <= '0;
            data_m      <= '0;
            data_n      <= '0;
            link_m      <= '0;
            link_n      <= '0;
            data_m_word <= '0;
            state_q     <= ST_IDLE;
          end
        end
        ST_MUL_DM: begin
          if (!mul_busy) begin
            red_go  <= 1'b1;
            dm_in   <= mul_prod;
            dn_in   <= avail;
            lm_in   <= WIDE_W'(pclk_q);
            ln_in   <= lclk_w;
            state_q <= ST_SHRINK;
          end
        end
        ST_SHRINK: begin
          if (!red_busy_d && !red_busy_l) begin
            done        <= 1'b1;
            fail        <= 1'b0;
            fail_slow   <= 1'b0;
            rate_code   <= rate_hi_q ? RATE_HI_CODE : RATE_LO_CODE;
            lane_cnt    <= 3'b001 << lane_log_q;
            data_m      <= dm_out;
            data_n      <= dn_out;
            link_m      <= lm_out;
            link_n      <= ln_out;
            data_m_word <= {TU_M1, dm_out};
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
  parameter int RATIO_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic               fail_slow,
  input logic [7:0]         rate_code,
  input logic [2:0]         lane_cnt,
  input logic [RATIO_W-1:0] data_m,
  input logic [RATIO_W-1:0] link_n
);
  assert_slow_is_fail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fail_slow |-> fail);

  assert_lane_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> ($countones(lane_cnt) == 1));

  assert_rate_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (rate_code == 8'h06 || rate_code == 8'h0A));

  assert_fail_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (lane_cnt == 3'd0 && rate_code == 8'd0 && data_m == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(data_m) && $stable(link_n) && $stable(lane_cnt)));
endmodule

bind link_ratio_calc lrc_checker #(.RATIO_W(RATIO_W)) u_lrc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .fail_slow(fail_slow),
  .rate_code(rate_code),
  .lane_cnt (lane_cnt),
  .data_m   (data_m),
  .link_n   (link_n)
);

// File: tb/link_ratio_calc_tb_top.sv
module link_ratio_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCLK_W     = 20;
  localparam int RATIO_W    = 16;
  localparam int WORD_W     = RATIO_W + 8;
  localparam longint LIM    = (64'd1 << RATIO_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PCLK_W-1:0] pix_khz = '0;
  logic panel_mode = 1'b0;
  logic [7:0] panel_bpp = '0, cap_rev = '0, cap_lane_byte = '0, cap_rate = '0;
  logic busy, done, fail, fail_slow;
  logic [7:0] rate_code;
  logic [2:0] lane_cnt;
  logic [RATIO_W-1:0] data_m, data_n, link_m, link_n;
  logic [WORD_W-1:0] data_m_word;

  link_ratio_calc #(.PCLK_W(PCLK_W), .RATIO_W(RATIO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz),
    .panel_mode(panel_mode), .panel_bpp(panel_bpp), .cap_rev(cap_rev),
    .cap_lane_byte(cap_lane_byte), .cap_rate(cap_rate), .busy(busy),
    .done(done), .fail(fail), .fail_slow(fail_slow), .rate_code(rate_code),
    .lane_cnt(lane_cnt), .data_m(data_m), .data_n(data_n), .link_m(link_m),
    .link_n(link_n), .data_m_word(data_m_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit pending = 1'b0;
  longint e_rate, e_lanes, e_fail, e_slow, e_dm, e_dn, e_lm, e_ln, e_word;
  longint p_rate = 0, p_lanes = 0, p_fail = 0, p_slow = 0, p_dm = 0, p_dn = 0,
          p_lm = 0, p_ln = 0, p_word = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference for one request
  task automatic model(input longint pclk, input bit panel, input longint bpp,
                       input longint rev, input longint lb, input longint rc);
    longint maxl, req, lk, lanes, dm, dn, lm, ln;
    bit hi, found;
    maxl = 4;
    if (rev >= 'h11) begin
      maxl = lb & 31;
      if (maxl != 1 && maxl != 2 && maxl != 4) maxl = 4;
    end
    hi = (rc == 'h0A);
    {e_rate, e_lanes, e_dm, e_dn, e_lm, e_ln, e_word} = '0;
    e_fail = 1; e_slow = 0;
    if (pclk < 10000) begin
      e_slow = 1;
      return;
    end
    req = panel ? (pclk * bpp) / 8 : pclk * 3;
    found = 0; lk = 0; lanes = 0;
    for (longint l = 1; l <= maxl && !found; l = l * 2)
      for (int r = 0; r <= int'(hi) && !found; r++) begin
        longint c;
        c = (r == 1) ? 270000 : 162000;
        if (req <= c * l) begin found = 1; lk = c; lanes = l; end
      end
    if (!found) return;
    dm = pclk * 3; dn = lk * lanes; lm = pclk; ln = lk;
    while (dm > LIM || dn > LIM) begin dm = dm >> 1; dn = dn >> 1; end
    while (lm > LIM || ln > LIM) begin lm = lm >> 1; ln = ln >> 1; end
    e_fail = 0;
    e_rate = (lk == 270000) ? 'h0A : 'h06;
    e_lanes = lanes;
    e_dm = dm; e_dn = dn; e_lm = lm; e_ln = ln;
    e_word = (longint'(63) << RATIO_W) | dm;
  endtask

  // Per-cycle comparison against the published reference state
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        chk("R9 done without request", longint'(pending), 1);
        p_rate = e_rate; p_lanes = e_lanes; p_fail = e_fail; p_slow = e_slow;
        p_dm = e_dm; p_dn = e_dn; p_lm = e_lm; p_ln = e_ln; p_word = e_word;
        pending = 1'b0;
      end
      chk("R10 rate_code", longint'(rate_code), p_rate);
      chk("R10 lane_cnt", longint'(lane_cnt), p_lanes);
      chk("R10 fail", longint'(fail), p_fail);
      chk("R10 fail_slow", longint'(fail_slow), p_slow);
      chk("R10 data_m", longint'(data_m), p_dm);
      chk("R10 data_n", longint'(data_n), p_dn);
      chk("R10 link_m", longint'(link_m), p_lm);
      chk("R10 link_n", longint'(link_n), p_ln);
      chk("R10 data_m_word", longint'(data_m_word), p_word);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R9 watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input longint pclk, input bit panel, input longint bpp,
                       input longint rev, input longint lb, input longint rc);
    pix_khz = PCLK_W'(pclk); panel_mode = panel; panel_bpp = 8'(bpp);
    cap_rev = 8'(rev); cap_lane_byte = 8'(lb); cap_rate = 8'(rc);
  endtask

  task automatic end_check(input string tag);
    chk({tag, " rate_code"}, longint'(rate_code), e_rate);
    chk({tag, " lane_cnt"}, longint'(lane_cnt), e_lanes);
    chk({tag, " fail"}, longint'(fail), e_fail);
    chk({tag, " fail_slow"}, longint'(fail_slow), e_slow);
    chk({tag, " data_m"}, longint'(data_m), e_dm);
    chk({tag, " data_n"}, longint'(data_n), e_dn);
    chk({tag, " link_m"}, longint'(link_m), e_lm);
    chk({tag, " link_n"}, longint'(link_n), e_ln);
    chk({tag, " data_m_word"}, longint'(data_m_word), e_word);
  endtask

  task automatic run(input string tag, input longint pclk, input bit panel,
                     input longint bpp, input longint rev, input longint lb,
                     input longint rc);
    @(negedge clk);
    drive(pclk, panel, bpp, rev, lb, rc);
    model(pclk, panel, bpp, rev, lb, rc);
    pending = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (e_slow == 0) chk("R9 busy after start", longint'(busy), 1);
    while (!done) @(negedge clk);
    end_check(tag);
    @(negedge clk);
    chk("R9 done one cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset done", longint'(done), 0);
    chk("R10 reset busy", longint'(busy), 0);
    chk("R10 reset data_m_word", longint'(data_m_word), 0);

    run("R3 one lane low rate", 25175, 0, 0, 'h11, 'h04, 'h0A);
    run("R3 exact fit", 54000, 0, 0, 'h11, 'h04, 'h0A);
    run("R7 two lanes high rate", 148500, 0, 0, 'h11, 'h04, 'h0A);
    run("R8 tu word", 21845, 0, 0, 'h11, 'h04, 'h06);
    run("R2 panel depth", 100000, 1, 18, 'h11, 'h04, 'h0A);
    run("R2 normal depth", 100000, 0, 18, 'h11, 'h04, 'h0A);
    run("R6 no fit lane cap", 148500, 0, 0, 'h11, 'h82, 'h06);
    run("R4 old revision", 148500, 0, 0, 'h10, 'h01, 'h06);
    run("R4 odd lane field", 148500, 0, 0, 'h12, 'h03, 'h06);
    run("R4 one lane cap", 60000, 0, 0, 'h11, 'h01, 'h0A);
    run("R5 unknown rate", 60000, 0, 0, 'h11, 'h04, 'h14);
    run("R1 below minimum", 9999, 0, 0, 'h11, 'h04, 'h0A);
    run("R1 at minimum", 10000, 0, 0, 'h11, 'h04, 'h0A);
    run("R6 panel too fast", 600000, 1, 30, 'h11, 'h04, 'h0A);

    // R9: a start while busy is ignored
    @(negedge clk);
    drive(148500, 0, 0, 'h11, 'h04, 'h0A);
    model(148500, 0, 0, 'h11, 'h04, 'h0A);
    pending = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    drive(25175, 0, 0, 'h11, 'h01, 'h06);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    end_check("R9 start while busy");
    repeat (30) @(negedge clk);
    chk("R9 no extra request", longint'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule